// File: doc/BRIEF.md
# Two-Plane Coincidence Trigger

This block lets a strip-readout detector trigger itself. Each 20 ns time slice, two upstream decoders report whether their strip plane saw any hit: one flag for the X plane, one for the Y plane. A 32-bit slice counter, the same one the decoders use to tag track data, comes in alongside the flags. When both planes report activity in the same slice, or within a programmable number of slices of each other, the block issues a one-cycle trigger. That trigger starts capture of the grid charge-amplifier waveform by a flash ADC.

On every trigger the block latches the slice counter value. Energy records and track records carry the same time base, so they can be matched directly by this timestamp. It also latches a capture origin, which is the trigger slice minus a programmable pre-trigger offset. This tells the waveform store how far back to read.

A capture-enable output stays high for a programmable number of slices. After each trigger, further triggers are held off for a programmable dead time (a typical setting is 512 slices). Coincidences that fall inside the dead time are counted as lost. Accepted triggers are counted separately.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is asserted and right after it is released, trig, cap_en, trig_ts, cap_origin, trig_count and lost_count are all zero.
- R2: A slice is a cycle with slice_en high. With cfg_win = 0, a slice with both hit_x and hit_y high produces trig = 1 in the next cycle, for exactly one cycle. A slice with only one plane hit produces no trigger.
- R3: With cfg_win = N, an X hit and a Y hit that are at most N slices apart, in either order, produce a trigger for the slice of the later hit. Hits N+1 slices apart produce none.
- R4: hit_x and hit_y are ignored in cycles with slice_en low. They neither trigger nor open a window.
- R5: When trig is high, trig_ts holds the slice_cnt value of the triggering slice. trig_ts keeps that value until the next trigger.
- R6: After a trigger, a coincidence in any of the next cfg_dead slices causes no trigger. A coincidence in the slice after those can trigger.
- R7: trig_count increments by one with each trigger. lost_count increments by one for each slice that holds a coincidence blocked by the dead time. Both wrap modulo 2^CNT_W.
- R8: cap_en rises in the same cycle as trig and stays high through the next cfg_cap_len slices, then falls. A new trigger restarts this count. cfg_cap_len = 0 leaves cap_en low.
- R9: On each trigger, cap_origin becomes the triggering slice_cnt minus cfg_pre, modulo 2^32. It holds that value until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_en | input | 1 | High for one cycle per 20 ns slice; qualifies the hit flags |
| hit_x | input | 1 | Any hit on the X plane in this slice |
| hit_y | input | 1 | Any hit on the Y plane in this slice |
| slice_cnt | input | 32 | Shared slice counter value for this slice |
| cfg_win | input | WIN_W | Coincidence window in slices (0 = same slice) |
| cfg_dead | input | DUR_W | Dead time in slices after a trigger |
| cfg_cap_len | input | DUR_W | Capture window length in slices |
| cfg_pre | input | DUR_W | Pre-trigger offset subtracted for cap_origin |
| trig | output | 1 | One-cycle trigger pulse |
| trig_ts | output | 32 | Slice counter value of the last trigger |
| cap_en | output | 1 | Capture window enable |
| cap_origin | output | 32 | Slice where the stored waveform window begins |
| trig_count | output | CNT_W | Accepted triggers |
| lost_count | output | CNT_W | Coincident slices blocked by dead time |

## Verification
The assertions assume three things about the inputs. The configuration does not change while a trigger is live. cfg_dead is nonzero whenever trig is checked for being a single-cycle pulse. Each slice presents one slice_cnt value. The bench follows these assumptions. It changes the configuration only while under reset, with all timers idle. It advances slice_cnt only on cycles with slice_en high. It keeps cfg_dead at least one in every phase. Random phases drop slice_en in about a quarter of the cycles and vary hit density and window width, so that blocked, windowed and idle slices all occur often.

// File: rtl/coinc_trigger_pkg.sv
package coinc_trigger_pkg;
  localparam int TS_W = 32;
  typedef logic [TS_W-1:0] slice_t;
endpackage

// File: rtl/coinc_plane_age.sv
// Tracks how many slices ago a plane last reported a hit and says
// whether that hit lies within the coincidence window.
module coinc_plane_age #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_en,
  input  logic             hit,
  input  logic [WIN_W-1:0] win,
  output logic             recent
);
  localparam logic [WIN_W-1:0] AGE_MAX = {WIN_W{1'b1}};

  logic             seen_q, seen_d;
  logic [WIN_W-1:0] age_q, age_d;   // slices since last hit, minus one

  always_comb begin
    seen_d = seen_q;
    age_d  = age_q;
    if (slice_en) begin
      if (hit) begin
        seen_d = 1'b1;
        age_d  = '0;
      end else if (seen_q && age_q != AGE_MAX) begin
        age_d = age_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      seen_q <= seen_d;
      age_q  <= age_d;
    end
  end

  // current hit, or an earlier one at most win slices back
  assign recent = hit || (seen_q && (age_q < win));
endmodule

// File: rtl/coinc_slice_timer.sv
// Down-counter in slice units; active while nonzero.
module coinc_slice_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slice_en,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = len;
    else if (slice_en && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_trigger_pkg::*;
#(
  parameter int WIN_W = 4,
  parameter int DUR_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_en,
  input  logic             hit_x,
  input  logic             hit_y,
  input  logic [TS_W-1:0]  slice_cnt,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic [DUR_W-1:0] cfg_dead,
  input  logic [DUR_W-1:0] cfg_cap_len,
  input  logic [DUR_W-1:0] cfg_pre,
  output logic             trig,
  output logic [TS_W-1:0]  trig_ts,
  output logic             cap_en,
  output logic [TS_W-1:0]  cap_origin,
  output logic [CNT_W-1:0] trig_count,
  output logic [CNT_W-1:0] lost_count
);
  localparam int NPLANE = 2;

  logic [NPLANE-1:0] plane_hit;
  logic [NPLANE-1:0] plane_recent;
  logic              coin, busy, fire, block;

  assign plane_hit = {hit_y, hit_x};

  genvar p;
  generate
    for (p = 0; p < NPLANE; p++) begin : g_plane
      coinc_plane_age #(.WIN_W(WIN_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .slice_en(slice_en),
        .hit     (plane_hit[p]),
        .win     (cfg_win),
        .recent  (plane_recent[p])
      );
    end
  endgenerate

  // a hit on one plane meets a recent (or simultaneous) hit on the other
  assign coin  = (plane_hit[0] && plane_recent[1]) ||
                 (plane_hit[1] && plane_recent[0]);
  assign fire  = slice_en && coin && !busy;
  assign block = slice_en && coin &&  busy;

  coinc_slice_timer #(.W(DUR_W)) u_dead (
    .clk     (clk),
    .rst_n   (rst_n),
    .slice_en(slice_en),
    .load    (fire),
    .len     (cfg_dead),
    .active  (busy)
  );

  coinc_slice_timer #(.W(DUR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .slice_en(slice_en),
    .load    (fire),
    .len     (cfg_cap_len),
    .active  (cap_en)
  );

  slice_t           ts_d, org_d;
  logic [CNT_W-1:0] tc_d, lc_d;

  always_comb begin
    ts_d  = trig_ts;
    org_d = cap_origin;
    tc_d  = trig_count;
    lc_d  = lost_count;
    if (fire) begin
      ts_d  = slice_cnt;
      org_d = slice_cnt - slice_t'(cfg_pre);
      tc_d  = trig_count + 1'b1;
    end
    if (block)
      lc_d = lost_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig       <= 1'b0;
      trig_ts    <= '0;
      cap_origin <= '0;
      trig_count <= '0;
      lost_count <= '0;
    end else begin
      trig       <= fire;
      trig_ts    <= ts_d;
      cap_origin <= org_d;
      trig_count <= tc_d;
      lost_count <= lc_d;
    end
  end
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int DUR_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slice_en,
  input logic [DUR_W-1:0] cfg_dead,
  input logic             trig,
  input logic [31:0]      trig_ts,
  input logic [31:0]      cap_origin,
  input logic             cap_en,
  input logic [CNT_W-1:0] trig_count,
  input logic [CNT_W-1:0] lost_count
);
  assert_trig_from_slice_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(slice_en));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_dead != '0) |=> !trig);

  assert_ts_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |-> $stable(trig_ts));

  assert_origin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |-> $stable(cap_origin));

  assert_cap_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_en) |-> trig);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (trig_count == $past(trig_count) + 1'b1));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |-> $stable(trig_count));

  assert_lost_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lost_count) |-> !trig);
endmodule

bind coinc_trigger coinc_trigger_chk #(.DUR_W(DUR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_en(slice_en), .cfg_dead(cfg_dead),
  .trig(trig), .trig_ts(trig_ts), .cap_origin(cap_origin), .cap_en(cap_en),
  .trig_count(trig_count), .lost_count(lost_count)
);

// File: tb/sim_coinc_trigger.sv
module sim_coinc_trigger;
  localparam int WIN_W = 4;
  localparam int DUR_W = 12;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             slice_en, hit_x, hit_y;
  logic [31:0]      slice_cnt;
  logic [WIN_W-1:0] cfg_win;
  logic [DUR_W-1:0] cfg_dead, cfg_cap_len, cfg_pre;
  logic             trig, cap_en;
  logic [31:0]      trig_ts, cap_origin;
  logic [CNT_W-1:0] trig_count, lost_count;

  always #2 clk = ~clk;

  coinc_trigger #(.WIN_W(WIN_W), .DUR_W(DUR_W), .CNT_W(CNT_W)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int          n, lx, ly, e_dead, e_cap;
  logic        e_trig;
  logic [31:0] e_ts, e_org;
  logic [CNT_W-1:0] e_tc, e_lc;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int now, input int last, input int w);
    return (now - last) >= 1 && (now - last) <= w;
  endfunction

  task automatic model_clear();
    n = 0; lx = -100000; ly = -100000; e_dead = 0; e_cap = 0;
    e_trig = 0; e_ts = 0; e_org = 0; e_tc = 0; e_lc = 0;
  endtask

  task automatic compare_all();
    chk(trig == e_trig, "R2 trig", trig, e_trig);
    chk(trig_ts == e_ts, "R5 trig_ts", trig_ts, e_ts);
    chk(cap_en == (e_cap != 0), "R8 cap_en", cap_en, e_cap != 0);
    chk(cap_origin == e_org, "R9 cap_origin", cap_origin, e_org);
    chk(trig_count == e_tc, "R7 trig_count", trig_count, e_tc);
    chk(lost_count == e_lc, "R7 lost_count", lost_count, e_lc);
  endtask

  task automatic step(input bit sen, input bit hx, input bit hy);
    bit rx, ry, coin, busy, fire;
    slice_en = sen; hit_x = hx; hit_y = hy;
    rx = hx || near(n, lx, int'(cfg_win));
    ry = hy || near(n, ly, int'(cfg_win));
    coin = sen && ((hx && ry) || (hy && rx));
    busy = (e_dead != 0);
    fire = coin && !busy;
    if (fire) begin
      e_trig = 1; e_ts = slice_cnt; e_org = slice_cnt - 32'(cfg_pre); e_tc++;
      e_dead = int'(cfg_dead); e_cap = int'(cfg_cap_len);
    end else begin
      e_trig = 0;
      if (coin) e_lc++;
      if (sen && e_dead > 0) e_dead--;
      if (sen && e_cap > 0) e_cap--;
    end
    if (sen) begin
      if (hx) lx = n;
      if (hy) ly = n;
      n++;
    end
    @(posedge clk);
    @(negedge clk);
    if (sen) slice_cnt = slice_cnt + 1;
    compare_all();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1, 0, 0);
  endtask

  task automatic do_reset(input int w, input int d, input int l, input int p, input logic [31:0] base);
    rst_n = 0;
    cfg_win = WIN_W'(w); cfg_dead = DUR_W'(d); cfg_cap_len = DUR_W'(l); cfg_pre = DUR_W'(p);
    slice_en = 0; hit_x = 0; hit_y = 0; slice_cnt = base;
    model_clear();
    repeat (3) @(negedge clk);
    compare_all();   // R1 under reset
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset values
    do_reset(0, 8, 4, 3, 32'h1000);
    chk(trig == 0 && cap_en == 0 && trig_count == 0 && lost_count == 0 && trig_ts == 0,
        "R1 reset state", trig_ts, 0);

    // R2: single plane never triggers; both in one slice does
    step(1, 1, 0); chk(trig == 0, "R2 x only", trig, 0);
    step(1, 0, 1); idle(1);
    step(1, 0, 1); chk(trig == 0, "R2 y only", trig, 0);
    idle(2);
    step(1, 1, 1); chk(trig == 1, "R2 coincidence", trig, 1);
    chk(trig_ts == slice_cnt - 1, "R5 timestamp", trig_ts, slice_cnt - 1);
    step(0, 0, 0); chk(trig == 0, "R2 one cycle", trig, 0);
    // R6: blocked inside dead time, counted lost
    step(1, 1, 1); chk(trig == 0 && lost_count == 1, "R6 blocked", lost_count, 1);
    idle(12);
    // R4: hits with slice_en low are ignored
    step(0, 1, 1); chk(trig == 0, "R4 gated", trig, 0);
    step(1, 0, 0); chk(trig == 0, "R4 no window", trig, 0);

    // R3: window of 2
    do_reset(2, 4, 2, 0, 32'hFFFF_FFF0);
    step(1, 1, 0); idle(1); step(1, 0, 1);
    chk(trig == 1, "R3 two apart", trig, 1);
    idle(8);
    step(1, 0, 1); idle(2); step(1, 1, 0);
    chk(trig == 0, "R3 three apart", trig, 0);
    idle(8);
    step(1, 0, 1); step(0, 1, 0); step(1, 0, 0); step(1, 1, 0);
    chk(trig == 1, "R3 y first, gap cycle not counted", trig, 1);

    // R6: 512-slice dead time boundary
    do_reset(0, 512, 20, 100, 32'h40);
    step(1, 1, 1);
    idle(511);
    step(1, 1, 1); chk(trig == 0, "R6 last dead slice", trig, 0);
    step(1, 1, 1); chk(trig == 1, "R6 first free slice", trig, 1);
    chk(cap_origin == trig_ts - 100, "R9 origin", cap_origin, trig_ts - 100);

    // R8: zero capture length
    do_reset(0, 2, 0, 0, 32'h0);
    step(1, 1, 1); chk(cap_en == 0, "R8 zero length", cap_en, 0);

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      int hp;
      do_reset($urandom_range(0, 3), $urandom_range(1, 20), $urandom_range(0, 12),
               $urandom_range(0, 4095), $urandom);
      hp = $urandom_range(5, 40);
      for (int i = 0; i < 2500; i++)
        step($urandom_range(0, 99) < 75, $urandom_range(0, 99) < hp, $urandom_range(0, 99) < hp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule